// File: doc/BRIEF.md
# Thermometer-Selected Differential Table Evaluator

This block evaluates a fixed integer function f(α) for any n-bit input in any order, without storing every output value. Inputs are grouped in blocks of 2Δ. One full-width base value is kept per block: the function at the block's midpoint α = Δ·(2m+1). The remaining values are rebuilt from Δ banks of narrow signed differences, where each difference is taken between two adjacent function values rather than against the base. Below the midpoint, a chain of differences walks downward from the base. At and above it, a chain walks upward.

The input is split into a block address, a half-block row address and a position within the row. A shift-and-invert thermometer mask chooses which banks join the chain. The unselected bank outputs are forced to zero. The base and the masked differences are then added in one signed sum. That sum inverts each operand's sign bit and adds a single folded constant in place of all the negative weights. All table contents are computed at elaboration from a parameterised curve, and the result is registered.

Top module: `dlut_eval`

## Requirements
- R1: On every rising clock edge at which `rst_n` is low, `result` becomes 0.
- R2: The input present at a rising edge appears on `result` right after that edge (one cycle of latency), and successive inputs may arrive in any order, one per cycle.
- R3: `result` is the low OUT_W bits, two's complement, of f(α) = floor(α² / 2^CURVE_SHIFT) − CURVE_OFFSET. With the defaults (8-bit input, 12-bit output, shift 4, offset 2048) this holds for all 256 inputs.
- R4: At every block midpoint α = Δ·(2m+1), the result equals the stored base value, and no difference is selected.
- R5: In the lower half of a block (bit lgΔ of α is 0, position j = α[lgΔ−1:0]), exactly Δ−j differences are selected, from banks j to Δ−1. At a block start (j = 0) all Δ banks are selected.
- R6: In the upper half of a block (bit lgΔ of α is 1), exactly j differences are selected, from banks 0 to j−1. The half-depth bank Δ−1 is never selected there.
- R7: A bank whose select bit is 0 contributes zero to the sum, whatever it outputs.
- R8: Results on both sides of zero are correct, including the inputs where f changes sign (α = 180 to 183 with the defaults).
- R9: The extreme inputs α = 0 and α = 2^n − 1 produce correct results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| arg | input | IN_W | Function argument α |
| result | output | OUT_W | Registered two's complement f(α) |

## Verification
Every result is due exactly one rising edge after its argument is sampled. The bench drives each argument at a falling edge and pushes the expected value into a scoreboard queue at the same moment. A monitor pops one entry one time unit after each rising edge, so each item is compared in the cycle its argument was captured, with no skew between driver and monitor. Reset results are sampled at falling edges while reset is held. The mask properties (chain length, the top bank in each half, zeroing of unselected banks) are checked every cycle against the live argument.

// File: rtl/dlut_pkg.sv
// Package: shared helpers for the differential table evaluator.
// Assumes the curve stays within 32-bit integer range for the chosen widths.
package dlut_pkg;

    // Reference curve: floor(x^2 / 2^shift) - offset, as a signed integer.
    function automatic int curve_point(input int x, input int shift, input int offset);
        return ((x * x) >>> shift) - offset;
    endfunction

endpackage

// File: rtl/dlut_addr_gen.sv
// Module: dlut_addr_gen
// Splits the argument into a block address (base table and top bank), a row
// address (other banks), and a thermometer mask of the banks to be summed.
// Assumes DELTA is a power of two, at least 2.
module dlut_addr_gen #(
    parameter int IN_W  = 8,
    parameter int DELTA = 4,
    localparam int LG     = $clog2(DELTA),
    localparam int ROW_W  = IN_W - LG,
    localparam int BLK_W  = IN_W - LG - 1
) (
    input  logic [IN_W-1:0]  arg,
    output logic [BLK_W-1:0] blk_addr,
    output logic [ROW_W-1:0] row_addr,
    output logic [DELTA-1:0] sel
);

    // Address split: block index drops the half bit, row index keeps it.
    always_comb begin
        blk_addr = arg[IN_W-1:LG+1];
        row_addr = arg[IN_W-1:LG];
    end

    // Thermometer mask: ones shifted by position, inverted in the upper half.
    always_comb begin
        sel = ({DELTA{1'b1}} << arg[LG-1:0]) ^ {DELTA{arg[LG]}};
    end

endmodule

// File: rtl/dlut_tables.sv
// Module: dlut_tables
// Holds the base table (one value per 2*DELTA inputs, at the block midpoint)
// and DELTA banks of adjacent-value differences. Banks 0..DELTA-2 have two rows
// per block. Bank DELTA-1 has one row per block and is read with the block
// address. All contents are computed at elaboration. Assumes every difference
// fits DIFF_W-bit two's complement and every value fits OUT_W bits.
module dlut_tables
    import dlut_pkg::*;
#(
    parameter int IN_W         = 8,
    parameter int DELTA        = 4,
    parameter int OUT_W        = 12,
    parameter int DIFF_W       = 7,
    parameter int CURVE_SHIFT  = 4,
    parameter int CURVE_OFFSET = 2048,
    localparam int LG     = $clog2(DELTA),
    localparam int ROW_W  = IN_W - LG,
    localparam int BLK_W  = IN_W - LG - 1,
    localparam int ROWS   = 1 << ROW_W,
    localparam int BLOCKS = 1 << BLK_W
) (
    input  logic [BLK_W-1:0]              blk_addr,
    input  logic [ROW_W-1:0]              row_addr,
    output logic [OUT_W-1:0]              base_val,
    output logic [DELTA-1:0][DIFF_W-1:0]  diff_val
);

    // Base image: f at the midpoint of every block.
    function automatic logic [BLOCKS*OUT_W-1:0] build_base();
        logic [BLOCKS*OUT_W-1:0] img;
        img = '0;
        for (int b = 0; b < BLOCKS; b++) begin
            img[b*OUT_W +: OUT_W] =
                OUT_W'(curve_point(b*2*DELTA + DELTA, CURVE_SHIFT, CURVE_OFFSET));
        end
        return img;
    endfunction

    // Full-depth bank image: lower rows step down, upper rows step up.
    function automatic logic [ROWS*DIFF_W-1:0] build_bank(input int k);
        logic [ROWS*DIFF_W-1:0] img;
        int lo;
        int d;
        img = '0;
        for (int r = 0; r < ROWS; r++) begin
            lo = r * DELTA;
            if ((r % 2) == 0) begin
                d = curve_point(lo + k, CURVE_SHIFT, CURVE_OFFSET)
                  - curve_point(lo + k + 1, CURVE_SHIFT, CURVE_OFFSET);
            end else begin
                d = curve_point(lo + k + 1, CURVE_SHIFT, CURVE_OFFSET)
                  - curve_point(lo + k, CURVE_SHIFT, CURVE_OFFSET);
            end
            img[r*DIFF_W +: DIFF_W] = DIFF_W'(d);
        end
        return img;
    endfunction

    // Half-depth top bank: only the lower-row step next to the midpoint.
    function automatic logic [BLOCKS*DIFF_W-1:0] build_top();
        logic [BLOCKS*DIFF_W-1:0] img;
        int lo;
        int d;
        img = '0;
        for (int b = 0; b < BLOCKS; b++) begin
            lo = b * 2 * DELTA;
            d = curve_point(lo + DELTA - 1, CURVE_SHIFT, CURVE_OFFSET)
              - curve_point(lo + DELTA, CURVE_SHIFT, CURVE_OFFSET);
            img[b*DIFF_W +: DIFF_W] = DIFF_W'(d);
        end
        return img;
    endfunction

    localparam logic [BLOCKS*OUT_W-1:0] BASE_IMG = build_base();

    // Base table read.
    always_comb begin
        base_val = BASE_IMG[int'(blk_addr)*OUT_W +: OUT_W];
    end

    for (genvar k = 0; k < DELTA; k++) begin : g_bank
        if (k == DELTA - 1) begin : g_top
            localparam logic [BLOCKS*DIFF_W-1:0] TOP_IMG = build_top();
            // Top bank read, shared address with the base table.
            always_comb begin
                diff_val[k] = TOP_IMG[int'(blk_addr)*DIFF_W +: DIFF_W];
            end
        end else begin : g_full
            localparam logic [ROWS*DIFF_W-1:0] BANK_IMG = build_bank(k);
            // Full-depth bank read by row.
            always_comb begin
                diff_val[k] = BANK_IMG[int'(row_addr)*DIFF_W +: DIFF_W];
            end
        end
    end

endmodule

// File: rtl/dlut_mask.sv
// Module: dlut_mask
// Gates each bank output with its select bit (AND), so unselected banks give
// zero. Purely combinational.
module dlut_mask #(
    parameter int DELTA  = 4,
    parameter int DIFF_W = 7
) (
    input  logic [DELTA-1:0]              sel,
    input  logic [DELTA-1:0][DIFF_W-1:0]  diff_val,
    output logic [DELTA-1:0][DIFF_W-1:0]  dsel
);

    for (genvar k = 0; k < DELTA; k++) begin : g_and
        // Replicated select bit ANDed with the bank word.
        always_comb begin
            dsel[k] = diff_val[k] & {DIFF_W{sel[k]}};
        end
    end

endmodule

// File: rtl/dlut_signed_sum.sv
// Module: dlut_signed_sum
// Adds the base value and DELTA signed differences as unsigned operands.
// Each sign bit is inverted, and one folded constant carries every negative
// weight. The result is taken modulo 2^OUT_W. Assumes the true sum fits
// OUT_W bits and that OUT_W > DIFF_W.
module dlut_signed_sum #(
    parameter int DELTA  = 4,
    parameter int OUT_W  = 12,
    parameter int DIFF_W = 7,
    localparam int PAD      = OUT_W - DIFF_W,
    localparam int FOLD_INT = -(1 << (OUT_W - 1)) - DELTA * (1 << (DIFF_W - 1)),
    localparam logic [OUT_W-1:0] FOLD = OUT_W'(FOLD_INT)
) (
    input  logic [OUT_W-1:0]              base_val,
    input  logic [DELTA-1:0][DIFF_W-1:0]  dsel,
    output logic [OUT_W-1:0]              sum
);

    logic [DELTA-1:0][OUT_W-1:0] opnd;

    for (genvar k = 0; k < DELTA; k++) begin : g_op
        // Unsigned operand: sign bit inverted, zero-extended.
        always_comb begin
            opnd[k] = {{PAD{1'b0}}, ~dsel[k][DIFF_W-1], dsel[k][DIFF_W-2:0]};
        end
    end

    // Accumulate the base (sign inverted), the folded constant and all operands.
    always_comb begin
        logic [OUT_W-1:0] acc;
        acc = {~base_val[OUT_W-1], base_val[OUT_W-2:0]} + FOLD;
        for (int k = 0; k < DELTA; k++) begin
            acc = acc + opnd[k];
        end
        sum = acc;
    end

endmodule

// File: rtl/dlut_eval.sv
// Module: dlut_eval (top)
// Fully random-access evaluator. It combines the address/mask generation, the
// tables, the masking and the signed sum, and registers the result with one
// cycle of latency. Assumes DELTA is a power of two, at least 2.
module dlut_eval #(
    parameter int IN_W         = 8,
    parameter int DELTA        = 4,
    parameter int OUT_W        = 12,
    parameter int DIFF_W       = 7,
    parameter int CURVE_SHIFT  = 4,
    parameter int CURVE_OFFSET = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IN_W-1:0]  arg,
    output logic [OUT_W-1:0] result
);

    localparam int LG    = $clog2(DELTA);
    localparam int ROW_W = IN_W - LG;
    localparam int BLK_W = IN_W - LG - 1;

    logic [BLK_W-1:0]             blk_addr;
    logic [ROW_W-1:0]             row_addr;
    logic [DELTA-1:0]             sel;
    logic [OUT_W-1:0]             base_val;
    logic [DELTA-1:0][DIFF_W-1:0] diff_val;
    logic [DELTA-1:0][DIFF_W-1:0] dsel;
    logic [OUT_W-1:0]             sum;

    dlut_addr_gen #(.IN_W(IN_W), .DELTA(DELTA)) u_addr (
        .arg      (arg),
        .blk_addr (blk_addr),
        .row_addr (row_addr),
        .sel      (sel)
    );

    dlut_tables #(
        .IN_W(IN_W), .DELTA(DELTA), .OUT_W(OUT_W), .DIFF_W(DIFF_W),
        .CURVE_SHIFT(CURVE_SHIFT), .CURVE_OFFSET(CURVE_OFFSET)
    ) u_tab (
        .blk_addr (blk_addr),
        .row_addr (row_addr),
        .base_val (base_val),
        .diff_val (diff_val)
    );

    dlut_mask #(.DELTA(DELTA), .DIFF_W(DIFF_W)) u_mask (
        .sel      (sel),
        .diff_val (diff_val),
        .dsel     (dsel)
    );

    dlut_signed_sum #(.DELTA(DELTA), .OUT_W(OUT_W), .DIFF_W(DIFF_W)) u_sum (
        .base_val (base_val),
        .dsel     (dsel),
        .sum      (sum)
    );

    // Output register with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else begin
            result <= sum;
        end
    end

    // Position within the row, used by the mask checks below.
    logic [LG-1:0] pos;
    always_comb begin
        pos = arg[LG-1:0];
    end

    // R1: a low reset at an edge leaves result at zero after it.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> result == '0);

    // R5: lower half selects DELTA - pos banks, including the top bank.
    p_lower_chain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !arg[LG] |-> ($countones(sel) == DELTA - int'(pos)) && sel[DELTA-1]);

    // R6: upper half selects pos banks and never the half-depth top bank.
    p_upper_chain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        arg[LG] |-> ($countones(sel) == int'(pos)) && !sel[DELTA-1]);

    // R4: at a block midpoint no difference reaches the sum.
    p_midpoint_bare_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (arg[LG] && pos == '0) |-> dsel == '0);

    for (genvar k = 0; k < DELTA; k++) begin : g_chk
        // R7: an unselected bank contributes a zero word.
        p_masked_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !sel[k] |-> dsel[k] == '0);
    end

endmodule

// File: tb/tb_dlut_eval.sv
// Scoreboard bench for dlut_eval with default parameters.
module tb_dlut_eval;

    logic        clk;
    logic        rst_n;
    logic [7:0]  arg;
    logic [11:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [11:0] exp_q[$];
    string       tag_q[$];

    dlut_eval dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .arg    (arg),
        .result (result)
    );

    initial clk = 0;
    always #5 clk = ~clk;

    // Requirement R3 curve with default parameters.
    function automatic logic [11:0] ref_f(input int x);
        int v;
        v = ((x * x) >> 4) - 2048;
        return v[11:0];
    endfunction

    task automatic check(input string tag, input logic [11:0] got, input logic [11:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // Driver: apply one argument and queue its expected result.
    task automatic drive(input int x, input string tag);
        @(negedge clk);
        arg = 8'(x);
        exp_q.push_back(ref_f(x));
        tag_q.push_back($sformatf("%s arg=%0d", tag, x));
    endtask

    // Monitor: one result per rising edge for each queued argument (R2).
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            check(tag_q.pop_front(), result, exp_q.pop_front());
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 0;
        arg   = 8'h55;
        // R1: result held at zero across several reset edges with busy input.
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R1 reset", result, 12'h000);
            arg = 8'(i * 91 + 7);
        end
        @(negedge clk);
        rst_n = 1;

        // R3: every input ascending.
        for (int x = 0; x < 256; x++) drive(x, "R3 ascending");
        // R2: descending order, back to back.
        for (int x = 255; x >= 0; x--) drive(x, "R2 descending");
        // R2/R7: stride 37 jumps across blocks and halves.
        for (int i = 0; i < 256; i++) drive((i * 37) % 256, "R2/R7 stride");
        // R4: block midpoints.
        for (int m = 0; m < 32; m++) drive(m * 8 + 4, "R4 midpoint");
        // R5: block starts (all banks) and lower-half cases 8, 9, 10.
        for (int m = 0; m < 32; m++) drive(m * 8, "R5 block start");
        drive(8, "R5 mask 1111");
        drive(9, "R5 mask 1110");
        drive(10, "R5 mask 1100");
        // R6: upper-half cases 13, 15 and top positions.
        drive(13, "R6 mask 0001");
        drive(15, "R6 mask 0111");
        for (int m = 0; m < 32; m++) drive(m * 8 + 7, "R6 upper end");
        // R8: sign change region.
        for (int x = 178; x <= 185; x++) drive(x, "R8 sign change");
        // R9: extremes alternating.
        drive(0, "R9 min");
        drive(255, "R9 max");
        drive(0, "R9 min");

        // R1 again: reset mid-stream clears result.
        @(negedge clk);
        @(negedge clk);
        rst_n = 0;
        arg   = 8'd200;
        @(negedge clk);
        check("R1 reset mid-run", result, 12'h000);
        rst_n = 1;
        drive(200, "R1 after reset");
        @(negedge clk);
        @(negedge clk);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule